// File: doc/BRIEF.md
# Pipelined Two-Phase Bus Master

This block connects a local requester to a synchronous, two-stage pipelined system bus. Every bus transfer has an address phase, in which the address and its attributes are driven, and then a data phase. The data phase lasts until the target acknowledges it. The address phase of the next transfer overlaps the data phase of the current one. When the target acknowledges every cycle, one transfer completes per clock.

The requester presents a transfer on a valid/ready port. The transfer carries an address, a size code, a write flag, a two-bit transfer type, a three-bit modifier and up to 128 bits of write data. A line transfer is split into four 32-bit beats. Each beat has its own address phase and its own acknowledge. For every acknowledged beat the requester gets a one-cycle completion pulse, and for reads the captured data comes with it.

Top module: `pbus_master`

## Requirements
- R1: While reset is active, and in the first cycle after it ends, `bus_aphase_o`, `bus_dphase_o`, `bus_wdata_oe_o` and `rsp_done_o` are low, `rsp_rdata_o` is zero and `req_ready_o` is high.
- R2: A request accepted at a clock edge (`req_valid_i` and `req_ready_o` high) appears in the next cycle on the address phase. `bus_aphase_o` is high and the type and modifier fields are passed through unchanged. Type codes: 00 processor, 01 alternate master, 10 emulator mode, 11 acknowledge/CPU space, where the modifier carries an interrupt level from 1 to 7, or 0 for CPU space.
- R3: An address phase moves into the data phase at a clock edge only if no data phase is active, or if the active one is acknowledged at that same edge. Until then, the address and attributes stay stable.
- R4: `bus_dphase_o` stays high until `bus_ack_i` is sampled high. `bus_ack_i` has no effect while no data phase is active.
- R5: For a write beat, `bus_wdata_o` holds that beat's data for the whole data phase. `bus_wdata_oe_o` is high exactly during data phases of writes.
- R6: `rsp_done_o` pulses in the cycle after each acknowledged beat. For a read, `rsp_rdata_o` shows the `bus_rdata_i` value sampled on the acknowledge edge. Otherwise `rsp_rdata_o` is zero.
- R7: With requests always valid and the target acknowledging every cycle, `rsp_done_o` is high in every cycle once the pipeline has filled.
- R8: Size code 11 is a line transfer of four beats. The size codes are 00 byte, 01 halfword, 10 word and 11 line, and the size is driven onto `bus_size_o` for every beat. Beat k uses address bits [3:2] equal to the requested value plus k, modulo 4, with all other bits unchanged. Beat k also carries `req_wline_i[32k+31:32k]`. Single transfers use bits [31:0].
- R9: `req_ready_o` is high only if the address stage is empty, or if it holds the last (or only) beat of its request and that beat moves to the data phase at the coming edge.
- R10: A reset in the middle of a transfer drops every pending beat. Both phase strobes go low and `req_ready_o` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_addr_i | input | 32 | Request byte address |
| req_size_i | input | 2 | Size code (00 byte, 01 half, 10 word, 11 line) |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_type_i | input | 2 | Transfer type |
| req_mod_i | input | 3 | Transfer modifier |
| req_wline_i | input | 128 | Write data; beat k uses word k |
| rsp_done_o | output | 1 | One pulse per completed beat |
| rsp_rdata_o | output | 32 | Read data of the completed beat |
| bus_aphase_o | output | 1 | Address phase strobe |
| bus_addr_o | output | 32 | Bus address |
| bus_size_o | output | 2 | Bus size code |
| bus_write_o | output | 1 | Bus write flag |
| bus_type_o | output | 2 | Bus transfer type |
| bus_mod_o | output | 3 | Bus transfer modifier |
| bus_dphase_o | output | 1 | Data phase strobe |
| bus_ack_i | input | 1 | Target acknowledge |
| bus_rdata_i | input | 32 | Read data from target |
| bus_wdata_o | output | 32 | Write data to target |
| bus_wdata_oe_o | output | 1 | Write data output enable |

## Verification
The assertions assume that the requester holds the request fields stable while `req_valid_i` is high and `req_ready_o` is low, and that line addresses are word aligned. The stimulus follows both rules: a request is replaced only after the reference model records its acceptance, and line addresses have bits [1:0] cleared. The target side is left unconstrained. The acknowledge is also driven randomly while no data phase is active, so that the bench confirms it is ignored.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_LINE = 2'b11
  } xfer_size_e;

  typedef enum logic [1:0] {
    TT_CPU   = 2'b00,
    TT_ALT   = 2'b01,
    TT_EMU   = 2'b10,
    TT_SPACE = 2'b11
  } xfer_type_e;
endpackage

// File: rtl/pbus_addr_stage.sv
module pbus_addr_stage
  import pbus_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BEATS = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  output logic                         req_ready_o,
  input  logic [ADDR_W-1:0]            req_addr_i,
  input  logic [1:0]                   req_size_i,
  input  logic                         req_write_i,
  input  logic [1:0]                   req_type_i,
  input  logic [2:0]                   req_mod_i,
  input  logic [DATA_W*LINE_BEATS-1:0] req_wline_i,
  input  logic                         advance_i,
  output logic                         ap_valid_o,
  output logic [ADDR_W-1:0]            ap_addr_o,
  output logic [1:0]                   ap_size_o,
  output logic                         ap_write_o,
  output logic [1:0]                   ap_type_o,
  output logic [2:0]                   ap_mod_o,
  output logic [DATA_W-1:0]            ap_wdata_o
);
  localparam int LINE_W     = DATA_W * LINE_BEATS;
  localparam int IDX_W      = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1;
  localparam int BYTE_OFF_W = $clog2(DATA_W / 8);
  localparam int LINE_OFF_W = BYTE_OFF_W + IDX_W;

  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic              write_q;
  logic [1:0]        type_q;
  logic [2:0]        mod_q;
  logic [LINE_W-1:0] wline_q;
  logic [IDX_W-1:0]  beat_q;
  logic              last_beat;
  logic              accept;
  logic [IDX_W-1:0]  word_sel;
  logic [DATA_W-1:0] words [LINE_BEATS];

  assign last_beat   = (size_q != SZ_LINE) || (beat_q == IDX_W'(LINE_BEATS - 1));
  assign req_ready_o = !valid_q || (advance_i && last_beat);
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      write_q <= 1'b0;
      type_q  <= '0;
      mod_q   <= '0;
      wline_q <= '0;
      beat_q  <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      addr_q  <= req_addr_i;
      size_q  <= req_size_i;
      write_q <= req_write_i;
      type_q  <= req_type_i;
      mod_q   <= req_mod_i;
      wline_q <= req_wline_i;
      beat_q  <= '0;
    end else if (advance_i) begin
      if (last_beat) valid_q <= 1'b0;
      else           beat_q  <= beat_q + IDX_W'(1);
    end
  end

  // beat address: word index wraps inside the aligned line
  assign word_sel  = addr_q[LINE_OFF_W-1:BYTE_OFF_W] + beat_q;
  assign ap_addr_o = {addr_q[ADDR_W-1:LINE_OFF_W], word_sel, addr_q[BYTE_OFF_W-1:0]};

  for (genvar g = 0; g < LINE_BEATS; g++) begin : g_word
    assign words[g] = wline_q[g*DATA_W +: DATA_W];
  end

  assign ap_wdata_o = words[beat_q];
  assign ap_valid_o = valid_q;
  assign ap_size_o  = size_q;
  assign ap_write_o = write_q;
  assign ap_type_o  = type_q;
  assign ap_mod_o   = mod_q;
endmodule

// File: rtl/pbus_data_stage.sv
module pbus_data_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              dp_valid_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wdata_oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              valid_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;
  logic              retire;

  assign retire = valid_q && ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      write_q <= write_i;
      wdata_q <= wdata_i;
    end else if (retire) begin
      valid_q <= 1'b0;
    end
  end

  // read data taken on the acknowledge edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q  <= retire;
      rdata_q <= (retire && !write_q) ? rdata_i : '0;
    end
  end

  assign dp_valid_o = valid_q;
  assign wdata_o    = wdata_q;
  assign wdata_oe_o = valid_q && write_q;
  assign done_o     = done_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/pbus_master.sv
module pbus_master #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BEATS = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  output logic                         req_ready_o,
  input  logic [ADDR_W-1:0]            req_addr_i,
  input  logic [1:0]                   req_size_i,
  input  logic                         req_write_i,
  input  logic [1:0]                   req_type_i,
  input  logic [2:0]                   req_mod_i,
  input  logic [DATA_W*LINE_BEATS-1:0] req_wline_i,
  output logic                         rsp_done_o,
  output logic [DATA_W-1:0]            rsp_rdata_o,
  output logic                         bus_aphase_o,
  output logic [ADDR_W-1:0]            bus_addr_o,
  output logic [1:0]                   bus_size_o,
  output logic                         bus_write_o,
  output logic [1:0]                   bus_type_o,
  output logic [2:0]                   bus_mod_o,
  output logic                         bus_dphase_o,
  input  logic                         bus_ack_i,
  input  logic [DATA_W-1:0]            bus_rdata_i,
  output logic [DATA_W-1:0]            bus_wdata_o,
  output logic                         bus_wdata_oe_o
);
  logic              ap_valid;
  logic              dp_valid;
  logic              advance;
  logic              ap_write;
  logic [DATA_W-1:0] ap_wdata;

  // overlap: next address phase moves on when current data phase retires
  assign advance = ap_valid && (!dp_valid || bus_ack_i);

  pbus_addr_stage #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BEATS(LINE_BEATS)
  ) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_addr_i  (req_addr_i),
    .req_size_i  (req_size_i),
    .req_write_i (req_write_i),
    .req_type_i  (req_type_i),
    .req_mod_i   (req_mod_i),
    .req_wline_i (req_wline_i),
    .advance_i   (advance),
    .ap_valid_o  (ap_valid),
    .ap_addr_o   (bus_addr_o),
    .ap_size_o   (bus_size_o),
    .ap_write_o  (ap_write),
    .ap_type_o   (bus_type_o),
    .ap_mod_o    (bus_mod_o),
    .ap_wdata_o  (ap_wdata)
  );

  pbus_data_stage #(.DATA_W(DATA_W)) u_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (advance),
    .write_i    (ap_write),
    .wdata_i    (ap_wdata),
    .ack_i      (bus_ack_i),
    .rdata_i    (bus_rdata_i),
    .dp_valid_o (dp_valid),
    .wdata_o    (bus_wdata_o),
    .wdata_oe_o (bus_wdata_oe_o),
    .done_o     (rsp_done_o),
    .rdata_o    (rsp_rdata_o)
  );

  assign bus_aphase_o = ap_valid;
  assign bus_dphase_o = dp_valid;
  assign bus_write_o  = ap_write;
endmodule

// File: rtl/pbus_master_chk.sv
module pbus_master_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_done_o,
  input logic              bus_aphase_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [1:0]        bus_size_o,
  input logic              bus_dphase_o,
  input logic              bus_ack_i,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_wdata_oe_o
);
  // R2
  accept_to_aphase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> bus_aphase_o);

  // R3
  aphase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_aphase_o && bus_dphase_o && !bus_ack_i |=>
      bus_aphase_o && $stable(bus_addr_o) && $stable(bus_size_o));

  // R3
  aphase_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_aphase_o && (!bus_dphase_o || bus_ack_i) |=> bus_dphase_o);

  // R4
  dphase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_dphase_o && !bus_ack_i |=> bus_dphase_o);

  // R5
  wdata_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_dphase_o && !bus_ack_i |=> $stable(bus_wdata_o) && $stable(bus_wdata_oe_o));

  // R5
  oe_in_dphase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wdata_oe_o |-> bus_dphase_o);

  // R6
  done_follows_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_dphase_o && bus_ack_i |=> rsp_done_o);

  // R6
  done_needs_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |-> $past(bus_dphase_o && bus_ack_i));
endmodule

bind pbus_master pbus_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/pbus_master_bench.sv
module pbus_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         req_valid_i;
  logic         req_ready_o;
  logic [31:0]  req_addr_i;
  logic [1:0]   req_size_i;
  logic         req_write_i;
  logic [1:0]   req_type_i;
  logic [2:0]   req_mod_i;
  logic [127:0] req_wline_i;
  logic         rsp_done_o;
  logic [31:0]  rsp_rdata_o;
  logic         bus_aphase_o;
  logic [31:0]  bus_addr_o;
  logic [1:0]   bus_size_o;
  logic         bus_write_o;
  logic [1:0]   bus_type_o;
  logic [2:0]   bus_mod_o;
  logic         bus_dphase_o;
  logic         bus_ack_i;
  logic [31:0]  bus_rdata_i;
  logic [31:0]  bus_wdata_o;
  logic         bus_wdata_oe_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pbus_master u_pbus_master (.*);

  typedef struct {
    logic [31:0] addr;
    logic [1:0]  size;
    logic        wr;
    logic [1:0]  tt;
    logic [2:0]  tm;
    logic [31:0] wd;
  } beat_t;

  beat_t       ap_q[$];
  beat_t       dp_q[$];
  logic        m_done;
  logic [31:0] m_rdata;
  bit          m_took;
  bit          m_adv;
  bit          m_ret;
  bit          m_rdy;
  int          errors = 0;
  int          checks = 0;
  bit          finished = 0;
  int          req_pct, ack_pct, line_pct;

  function automatic bit model_ready();
    return ap_q.size() == 0 || (ap_q.size() == 1 && (dp_q.size() == 0 || bus_ack_i));
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ap_q.delete();
      dp_q.delete();
      m_done  = 1'b0;
      m_rdata = '0;
      m_took  = 1'b0;
    end else begin
      m_rdy   = model_ready();
      m_adv   = ap_q.size() > 0 && (dp_q.size() == 0 || bus_ack_i);
      m_ret   = dp_q.size() > 0 && bus_ack_i;
      m_done  = m_ret;
      m_rdata = (m_ret && !dp_q[0].wr) ? bus_rdata_i : '0;
      if (m_ret) void'(dp_q.pop_front());
      if (m_adv) dp_q.push_back(ap_q.pop_front());
      m_took = req_valid_i && m_rdy;
      if (m_took) begin
        for (int k = 0; k < ((req_size_i == 2'b11) ? 4 : 1); k++) begin
          beat_t b;
          b.addr = {req_addr_i[31:4], 2'(req_addr_i[3:2] + k), req_addr_i[1:0]};
          b.size = req_size_i;
          b.wr   = req_write_i;
          b.tt   = req_type_i;
          b.tm   = req_mod_i;
          b.wd   = req_wline_i[32*k +: 32];
          ap_q.push_back(b);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit    ap;
    string at;
    ap = ap_q.size() > 0;
    chk(req_ready_o == model_ready(), "R9 ready", 128'(req_ready_o), 128'(model_ready()));
    chk(bus_aphase_o == ap, "R3 aphase", 128'(bus_aphase_o), 128'(ap));
    if (ap) begin
      at = (ap_q[0].size == 2'b11) ? "R8 line beat" : "R3 attrs";
      chk(bus_addr_o == ap_q[0].addr, at, 128'(bus_addr_o), 128'(ap_q[0].addr));
      chk(bus_size_o == ap_q[0].size, at, 128'(bus_size_o), 128'(ap_q[0].size));
      chk(bus_write_o == ap_q[0].wr, at, 128'(bus_write_o), 128'(ap_q[0].wr));
      chk({bus_type_o, bus_mod_o} == {ap_q[0].tt, ap_q[0].tm}, "R2 type/mod",
          128'({bus_type_o, bus_mod_o}), 128'({ap_q[0].tt, ap_q[0].tm}));
    end
    chk(bus_dphase_o == (dp_q.size() > 0), "R4 dphase", 128'(bus_dphase_o), 128'(dp_q.size() > 0));
    if (dp_q.size() > 0) begin
      chk(bus_wdata_oe_o == dp_q[0].wr, "R5 oe", 128'(bus_wdata_oe_o), 128'(dp_q[0].wr));
      if (dp_q[0].wr)
        chk(bus_wdata_o == dp_q[0].wd, "R5 wdata", 128'(bus_wdata_o), 128'(dp_q[0].wd));
    end else begin
      chk(bus_wdata_oe_o == 1'b0, "R5 oe idle", 128'(bus_wdata_oe_o), 128'(0));
    end
    chk(rsp_done_o == m_done, "R6 done", 128'(rsp_done_o), 128'(m_done));
    chk(rsp_rdata_o == m_rdata, "R6 rdata", 128'(rsp_rdata_o), 128'(m_rdata));
  endtask

  task automatic new_request();
    req_valid_i = 1'b1;
    req_write_i = 1'($urandom);
    req_type_i  = 2'($urandom);
    req_mod_i   = 3'($urandom);
    req_wline_i = {$urandom, $urandom, $urandom, $urandom};
    if (int'($urandom_range(0, 99)) < line_pct) begin
      req_size_i = 2'b11;
      req_addr_i = {$urandom} & 32'hFFFF_FFFC;
    end else begin
      req_size_i = 2'($urandom_range(0, 2));
      req_addr_i = $urandom;
    end
  endtask

  task automatic drive();
    bus_ack_i   = int'($urandom_range(0, 99)) < ack_pct;
    bus_rdata_i = $urandom;
    if (!req_valid_i || m_took) begin
      if (int'($urandom_range(0, 99)) < req_pct) new_request();
      else req_valid_i = 1'b0;
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      compare();
      drive();
    end
  endtask

  task automatic check_idle(input string tag);
    chk(!bus_aphase_o && !bus_dphase_o && !bus_wdata_oe_o, {tag, " strobes"},
        128'({bus_aphase_o, bus_dphase_o, bus_wdata_oe_o}), 128'(0));
    chk(!rsp_done_o && rsp_rdata_o == '0, {tag, " response"},
        128'({rsp_done_o, rsp_rdata_o}), 128'(0));
    chk(req_ready_o, {tag, " ready"}, 128'(req_ready_o), 128'(1));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL R4 watchdog expired actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
      summary();
      $finish;
    end
  end

  initial begin
    int cnt;
    rst_ni = 1'b0;
    req_valid_i = 1'b0; req_addr_i = '0; req_size_i = '0; req_write_i = 1'b0;
    req_type_i = '0; req_mod_i = '0; req_wline_i = '0;
    bus_ack_i = 1'b0; bus_rdata_i = '0;
    req_pct = 0; ack_pct = 0; line_pct = 0;
    repeat (3) @(negedge clk_i);
    check_idle("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("R1 after reset");

    // R2: directed interrupt-acknowledge read, level 5
    req_valid_i = 1'b1; req_addr_i = 32'hFFFF_FFF4; req_size_i = 2'b10;
    req_write_i = 1'b0; req_type_i = 2'b11; req_mod_i = 3'd5; req_wline_i = '0;
    @(negedge clk_i);
    chk(bus_aphase_o && bus_type_o == 2'b11 && bus_mod_o == 3'd5, "R2 iack attrs",
        128'({bus_aphase_o, bus_type_o, bus_mod_o}), 128'({1'b1, 2'b11, 3'd5}));
    req_valid_i = 1'b0;
    step(4);

    // R8: directed line write with wrapping address
    req_valid_i = 1'b1; req_addr_i = 32'h1000_0038; req_size_i = 2'b11;
    req_write_i = 1'b1; req_type_i = 2'b00; req_mod_i = 3'd1;
    req_wline_i = 128'h4444_4444_3333_3333_2222_2222_1111_1111;
    @(negedge clk_i);
    req_valid_i = 1'b0; bus_ack_i = 1'b1;
    chk(bus_addr_o == 32'h1000_0038, "R8 beat0 addr", 128'(bus_addr_o), 128'(32'h1000_0038));
    @(negedge clk_i);
    chk(bus_addr_o == 32'h1000_003C, "R8 beat1 addr", 128'(bus_addr_o), 128'(32'h1000_003C));
    chk(bus_wdata_o == 32'h1111_1111, "R8 beat0 data", 128'(bus_wdata_o), 128'(32'h1111_1111));
    @(negedge clk_i);
    chk(bus_addr_o == 32'h1000_0030, "R8 beat2 addr wrap", 128'(bus_addr_o), 128'(32'h1000_0030));
    chk(bus_wdata_o == 32'h2222_2222, "R8 beat1 data", 128'(bus_wdata_o), 128'(32'h2222_2222));
    @(negedge clk_i);
    chk(bus_addr_o == 32'h1000_0034, "R8 beat3 addr", 128'(bus_addr_o), 128'(32'h1000_0034));
    bus_ack_i = 1'b0;
    step(8);

    // random traffic, slow and stalling target (R3 R4 R5 R6 R9)
    req_pct = 70; ack_pct = 40; line_pct = 25;
    step(3000);
    req_pct = 100; ack_pct = 15; line_pct = 50;
    step(3000);

    // R7: full throughput
    req_pct = 100; ack_pct = 100; line_pct = 0;
    step(5);
    cnt = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      compare();
      if (rsp_done_o) cnt++;
      drive();
    end
    chk(cnt == 30, "R7 one beat per clock", 128'(cnt), 128'(30));

    // R10: reset in the middle of traffic
    req_pct = 100; ack_pct = 30; line_pct = 60;
    step(23);
    rst_ni = 1'b0;
    req_valid_i = 1'b0;
    @(negedge clk_i);
    check_idle("R10 mid reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("R10 after reset");
    step(2000);

    finished = 1;
    summary();
    $finish;
  end
endmodule